// File: doc/BRIEF.md
# Sobel Edge Stencil Unit

This unit turns a stream of 3x3 pixel neighbourhoods into a stream of edge pixels. Each clock it can take one window of nine pixels, along with a valid flag and the row and column of the centre pixel. It applies a horizontal and a vertical Sobel kernel to the window. It clamps each of the two signed gradients to the pixel range, adds the two clamped values, and subtracts the sum from full white. Strong edges therefore come out dark and flat areas come out white.

Centre positions on the outer ring of the frame are not filtered. They produce a zero pixel with valid still asserted, so that every input window maps to exactly one output. The data, valid flag and position pass through a fixed three-stage pipeline. An upstream line-buffer block builds the windows; this unit does not hold any frame or line storage.

Top module: `sobel_edge_unit`

## Requirements
- R1: The window input packs pixel (r,c) (r = row from top, c = column from left, each 0..2) at bits [8*(3*r+c) +: 8]. The horizontal gradient is gx = (p(0,2) + 2*p(1,2) + p(2,2)) - (p(0,0) + 2*p(1,0) + p(2,0)).
- R2: The vertical gradient is gy = (p(2,0) + 2*p(2,1) + p(2,2)) - (p(0,0) + 2*p(0,1) + p(0,2)).
- R3: Each gradient is clamped on its own to 0..255 before the two are added. A negative gradient counts as 0 and a gradient above 255 counts as 255.
- R4: For a non-border window the output pixel is 255 - (clamp(gx) + clamp(gy)), and it is 0 whenever that sum exceeds 255. A uniform window gives 255.
- R5: A window whose centre row is 0 or IMG_H-1, or whose centre column is 0 or IMG_W-1, gives an output pixel of 0 with valid_o high. Positions just inside this ring are filtered normally.
- R6: valid_o, row_o and col_o equal valid_i, row_i and col_i from exactly three clocks earlier. pix_o belongs to the window accepted at that same clock. An input with valid_i low produces an output with valid_o low.
- R7: Windows presented on consecutive clocks are all accepted, and the results come out on consecutive clocks in the same order.
- R8: While rst_ni is low, valid_o and pix_o are 0, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Window on win_i is valid this clock |
| win_i | input | 9*PIX_W | 3x3 window, pixel (r,c) at index 3*r+c |
| row_i | input | $clog2(IMG_H) | Row of the centre pixel |
| col_i | input | $clog2(IMG_W) | Column of the centre pixel |
| valid_o | output | 1 | Output pixel valid |
| pix_o | output | PIX_W | Edge pixel, dark on edges |
| row_o | output | $clog2(IMG_H) | Row of the output pixel |
| col_o | output | $clog2(IMG_W) | Column of the output pixel |

## Verification
The bench builds the unit with PIX_W=8, IMG_W=8 and IMG_H=6. With this small frame, every side of the border ring and the first interior positions can be reached with a few positions, and the 3-bit position fields still show the wrap at the far edges. The pixel width is kept at its default, so the gradients can reach ±1020. This covers clamping at both ends, a summed weight up to 510, and the window where clamping before the sum and clamping after it give different results.

// File: rtl/sobel_pkg.sv
package sobel_pkg;

  localparam int unsigned WIN_TAPS = 9;

  typedef enum logic {
    DIR_X = 1'b0,
    DIR_Y = 1'b1
  } grad_dir_e;

  // Sobel coefficient at window position (r,c): sign along the gradient axis, weight 2 on the middle line
  function automatic int sobel_coef(grad_dir_e dir, int r, int c);
    int along;
    int across;
    along  = (dir == DIR_X) ? c - 1 : r - 1;
    across = (dir == DIR_X) ? r : c;
    return along * ((across == 1) ? 2 : 1);
  endfunction

endpackage

// File: rtl/sobel_grad.sv
module sobel_grad
  import sobel_pkg::*;
#(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned GRAD_W = PIX_W + 3,
  parameter grad_dir_e   DIR    = DIR_X
) (
  input  logic [WIN_TAPS*PIX_W-1:0] win_i,
  output logic signed [GRAD_W-1:0]  grad_o
);

  logic signed [GRAD_W-1:0] term [WIN_TAPS];

  for (genvar t = 0; t < WIN_TAPS; t++) begin : g_tap
    localparam int                       R    = t / 3;
    localparam int                       C    = t % 3;
    localparam logic signed [GRAD_W-1:0] COEF = GRAD_W'(sobel_coef(DIR, R, C));
    logic signed [GRAD_W-1:0] pix_ext;
    assign pix_ext = $signed({{(GRAD_W-PIX_W){1'b0}}, win_i[t*PIX_W +: PIX_W]});
    assign term[t] = pix_ext * COEF;
  end

  always_comb begin
    grad_o = '0;
    for (int i = 0; i < WIN_TAPS; i++) grad_o = grad_o + term[i];
  end

endmodule

// File: rtl/sobel_clamp.sv
module sobel_clamp #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned GRAD_W = PIX_W + 3
) (
  input  logic signed [GRAD_W-1:0] grad_i,
  output logic [PIX_W-1:0]         clip_o
);

  localparam int unsigned PIX_MAX = (1 << PIX_W) - 1;

  always_comb begin
    if (grad_i[GRAD_W-1])                            clip_o = '0;
    else if ($unsigned(grad_i) > GRAD_W'(PIX_MAX))   clip_o = PIX_W'(PIX_MAX);
    else                                             clip_o = grad_i[PIX_W-1:0];
  end

endmodule

// File: rtl/sobel_edge_unit.sv
module sobel_edge_unit
  import sobel_pkg::*;
#(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned IMG_W = 512,
  parameter int unsigned IMG_H = 512,
  localparam int unsigned ROW_W = $clog2(IMG_H),
  localparam int unsigned COL_W = $clog2(IMG_W)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic [WIN_TAPS*PIX_W-1:0] win_i,
  input  logic [ROW_W-1:0]          row_i,
  input  logic [COL_W-1:0]          col_i,
  output logic                      valid_o,
  output logic [PIX_W-1:0]          pix_o,
  output logic [ROW_W-1:0]          row_o,
  output logic [COL_W-1:0]          col_o
);

  localparam int unsigned GRAD_W = PIX_W + 3;
  localparam int unsigned SUM_W  = PIX_W + 1;
  localparam int unsigned N_DIR  = 2;

  logic signed [GRAD_W-1:0] grad_w [N_DIR];
  logic signed [GRAD_W-1:0] grad_q [N_DIR];
  logic [PIX_W-1:0]         clip_w [N_DIR];
  logic [PIX_W-1:0]         clip_q [N_DIR];

  logic             border_w;
  logic             v1_q, v2_q, b1_q, b2_q;
  logic [ROW_W-1:0] row1_q, row2_q;
  logic [COL_W-1:0] col1_q, col2_q;
  logic [SUM_W-1:0] weight_w;

  // stage 0 (comb): both gradients
  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    sobel_grad #(
      .PIX_W (PIX_W),
      .GRAD_W(GRAD_W),
      .DIR   (grad_dir_e'(d))
    ) u_grad (
      .win_i (win_i),
      .grad_o(grad_w[d])
    );

    sobel_clamp #(
      .PIX_W (PIX_W),
      .GRAD_W(GRAD_W)
    ) u_clamp (
      .grad_i(grad_q[d]),
      .clip_o(clip_w[d])
    );
  end

  assign border_w = (row_i == '0) || (row_i == ROW_W'(IMG_H - 1)) ||
                    (col_i == '0) || (col_i == COL_W'(IMG_W - 1));

  // stage 1: gradients, stage 2: clamped gradients
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q   <= 1'b0;
      v2_q   <= 1'b0;
      b1_q   <= 1'b0;
      b2_q   <= 1'b0;
      row1_q <= '0;
      row2_q <= '0;
      col1_q <= '0;
      col2_q <= '0;
      for (int d = 0; d < N_DIR; d++) begin
        grad_q[d] <= '0;
        clip_q[d] <= '0;
      end
    end else begin
      v1_q   <= valid_i;
      b1_q   <= border_w;
      row1_q <= row_i;
      col1_q <= col_i;
      v2_q   <= v1_q;
      b2_q   <= b1_q;
      row2_q <= row1_q;
      col2_q <= col1_q;
      for (int d = 0; d < N_DIR; d++) begin
        grad_q[d] <= grad_w[d];
        clip_q[d] <= clip_w[d];
      end
    end
  end

  assign weight_w = {1'b0, clip_q[0]} + {1'b0, clip_q[1]};

  // stage 3: max - weight; for weight <= max this is the bitwise inverse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pix_o   <= '0;
      row_o   <= '0;
      col_o   <= '0;
    end else begin
      valid_o <= v2_q;
      row_o   <= row2_q;
      col_o   <= col2_q;
      if (b2_q || weight_w[PIX_W]) pix_o <= '0;
      else                         pix_o <= ~weight_w[PIX_W-1:0];
    end
  end

endmodule

// File: rtl/sobel_edge_chk.sv
module sobel_edge_chk #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned IMG_W = 512,
  parameter int unsigned IMG_H = 512,
  localparam int unsigned ROW_W = $clog2(IMG_H),
  localparam int unsigned COL_W = $clog2(IMG_W)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [9*PIX_W-1:0] win_i,
  input logic [ROW_W-1:0]   row_i,
  input logic [COL_W-1:0]   col_i,
  input logic               valid_o,
  input logic [PIX_W-1:0]   pix_o,
  input logic [ROW_W-1:0]   row_o,
  input logic [COL_W-1:0]   col_o
);

  localparam int DEPTH = 3;

  logic             vq [DEPTH];
  logic             fq [DEPTH];
  logic [ROW_W-1:0] rq [DEPTH];
  logic [COL_W-1:0] cq [DEPTH];
  logic             flat_in;

  always_comb begin
    flat_in = (row_i != '0) && (row_i != ROW_W'(IMG_H - 1)) &&
              (col_i != '0) && (col_i != COL_W'(IMG_W - 1));
    for (int k = 1; k < 9; k++)
      if (win_i[k*PIX_W +: PIX_W] != win_i[PIX_W-1:0]) flat_in = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) begin
        vq[k] <= 1'b0;
        fq[k] <= 1'b0;
        rq[k] <= '0;
        cq[k] <= '0;
      end
    end else begin
      vq[0] <= valid_i;
      fq[0] <= flat_in;
      rq[0] <= row_i;
      cq[0] <= col_i;
      for (int k = 1; k < DEPTH; k++) begin
        vq[k] <= vq[k-1];
        fq[k] <= fq[k-1];
        rq[k] <= rq[k-1];
        cq[k] <= cq[k-1];
      end
    end
  end

  AST_VALID_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == vq[DEPTH-1]); // R6

  AST_POS_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (row_o == rq[DEPTH-1]) && (col_o == cq[DEPTH-1])); // R6

  AST_BORDER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ((row_o == '0) || (row_o == ROW_W'(IMG_H - 1)) ||
                (col_o == '0) || (col_o == COL_W'(IMG_W - 1))) |-> pix_o == '0); // R5

  AST_FLAT_WHITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && fq[DEPTH-1] |-> pix_o == '1); // R4

endmodule

bind sobel_edge_unit sobel_edge_chk #(
  .PIX_W(PIX_W),
  .IMG_W(IMG_W),
  .IMG_H(IMG_H)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .win_i  (win_i),
  .row_i  (row_i),
  .col_i  (col_i),
  .valid_o(valid_o),
  .pix_o  (pix_o),
  .row_o  (row_o),
  .col_o  (col_o)
);

// File: tb/sobel_edge_unit_bench.sv
module sobel_edge_unit_bench;

  localparam int PIX_W = 8;
  localparam int IMG_W = 8;
  localparam int IMG_H = 6;
  localparam int ROW_W = $clog2(IMG_H);
  localparam int COL_W = $clog2(IMG_W);
  localparam int LAT   = 3;
  localparam int NV    = 15;

  // window bytes listed p(2,2) .. p(0,0), i.e. pixel index 8 down to 0
  localparam logic [71:0] WIN_T [NV] = '{
    72'h646464646464646464, // 0  R4 uniform -> 255
    72'hC80000C80000C80000, // 1  R1 R3 right column 200: gx 800 -> 255, gy 0
    72'h0A00000A00000A0000, // 2  R1 gx 40
    72'h00000A00000A00000A, // 3  R3 gx -40 -> 0
    72'h0A0A0A000000000000, // 4  R2 gy 40
    72'h1E0000000000000000, // 5  R2 gx 30 gy 30
    72'hC8C8C8C80000C80000, // 6  R4 weight 510 -> 0
    72'h000000640000640000, // 7  R3 gx 300 gy -100: clamp first -> 0
    72'hC80000000000000000, // 8  R4 weight 400 -> 0
    72'h0A00000A00000A0000, // 9  R5 row 0
    72'h0A00000A00000A0000, // 10 R5 last column
    72'h0A00000A00000A0000, // 11 R5 last row
    72'h0A00000A00000A0000, // 12 R5 column 0
    72'h0A00000A00000A0000, // 13 R5 first interior corner
    72'h0A00000A00000A0000  // 14 R6 invalid input
  };
  localparam int ROW_T [NV] = '{2, 2, 2, 2, 2, 3, 3, 4, 4, 0, 2, 5, 3, 1, 2};
  localparam int COL_T [NV] = '{3, 3, 4, 5, 6, 1, 2, 3, 4, 3, 7, 3, 0, 1, 5};
  localparam int VAL_T [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 0};
  localparam int EXP_T [NV] = '{255, 0, 215, 255, 215, 195, 0, 0, 0, 0, 0, 0, 0, 215, 0};
  localparam int REQ_T [NV] = '{4, 1, 1, 3, 2, 2, 4, 3, 4, 5, 5, 5, 5, 5, 6};

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               valid_i = 1'b0;
  logic [9*PIX_W-1:0] win_i = '0;
  logic [ROW_W-1:0]   row_i = '0;
  logic [COL_W-1:0]   col_i = '0;
  logic               valid_o;
  logic [PIX_W-1:0]   pix_o;
  logic [ROW_W-1:0]   row_o;
  logic [COL_W-1:0]   col_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  sobel_edge_unit #(
    .PIX_W(PIX_W),
    .IMG_W(IMG_W),
    .IMG_H(IMG_H)
  ) u_sobel_edge_unit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .win_i  (win_i),
    .row_i  (row_i),
    .col_i  (col_i),
    .valid_o(valid_o),
    .pix_o  (pix_o),
    .row_o  (row_o),
    .col_o  (col_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input int idx);
    valid_i = VAL_T[idx][0];
    win_i   = WIN_T[idx];
    row_i   = ROW_W'(ROW_T[idx]);
    col_i   = COL_W'(COL_T[idx]);
  endtask

  task automatic expect_vec(input int idx);
    string tag;
    tag = $sformatf("R%0d vec%0d", REQ_T[idx], idx);
    chk({tag, " valid"}, int'(valid_o), VAL_T[idx]);
    if (VAL_T[idx] != 0) begin
      chk({tag, " pix"}, int'(pix_o), EXP_T[idx]);
      chk({tag, " row (R6)"}, int'(row_o), ROW_T[idx]);
      chk({tag, " col (R6)"}, int'(col_o), COL_T[idx]);
    end
  endtask

  initial begin
    // R8: outputs quiet under reset even with valid input applied
    drive(2);
    repeat (3) @(negedge clk_i);
    chk("R8 reset valid_o", int'(valid_o), 0);
    chk("R8 reset pix_o", int'(pix_o), 0);
    valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R7: whole table streamed on consecutive clocks
    for (int j = 0; j < NV + LAT; j++) begin
      @(negedge clk_i);
      if (j >= LAT) expect_vec(j - LAT);
      if (j < NV) drive(j);
      else valid_i = 1'b0;
    end

    // R6: single window, exact latency
    @(negedge clk_i);
    drive(2);
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R6 latency t+1", int'(valid_o), 0);
    @(negedge clk_i);
    chk("R6 latency t+2", int'(valid_o), 0);
    @(negedge clk_i);
    chk("R6 latency t+3 valid", int'(valid_o), 1);
    chk("R6 latency t+3 pix", int'(pix_o), 215);
    @(negedge clk_i);
    chk("R6 latency t+4", int'(valid_o), 0);

    // R8: reset in the middle of a stream clears the output at once
    drive(0);
    repeat (4) @(negedge clk_i);
    chk("R8 pre-reset valid", int'(valid_o), 1);
    chk("R8 pre-reset pix", int'(pix_o), 255);
    rst_ni = 1'b0;
    #1;
    chk("R8 async valid_o", int'(valid_o), 0);
    chk("R8 async pix_o", int'(pix_o), 0);
    valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R8 after reset idle", int'(valid_o), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule